// File: doc/BRIEF.md
# Packet-Command PIO Burst Read Sequencer

This block is the device-side sequencer for a packet-command read over a 16-bit programmed-I/O task file. The host first loads a byte-count limit into two byte registers. It then writes the packet command code 0xA0 and sends a 12-byte command packet through the data port. The sequencer decodes the read opcode, the block address and the block count. It fetches words from a block source with a one-cycle read latency and hands them back to the host in bursts. No burst is longer than the limit allows.

Each burst is announced by an interrupt, and the status register then shows the data request bit. When the last word of the transfer has been read, the sequencer raises a separate completion interrupt. Any opcode other than read ends the command with an abort error. The feature register can be written, but the sequencer always transfers in PIO mode, whatever value that register holds.

Top module: `pkt_pio_burst_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40 (DRDY only), the error register (address 1) reads 0x00, and `irq` is low. Status bit positions: BSY=7, DRDY=6, DF=5, DRQ=3, ERR=0.
- R2: In the idle state, byte writes to address 4 and address 5 set the low and high bytes of the byte-count limit, and both read back. Writing 0xA0 to address 7 in the idle state makes the status read 0x48 (DRQ and DRDY) on the next cycle, whatever value was written to the feature register (address 1).
- R3: The packet is six data-port writes (address 0). Each word carries packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte 0 is the opcode, read = 0x28. Bytes 2..5 hold the 32-bit block address, most significant byte first. Bytes 7..8 hold the 16-bit block count, most significant byte first. DRQ clears as soon as the sixth word has been taken.
- R4: A burst holds min(floor(limit/2), remaining words) words, so an odd limit is rounded down to even. A limit below 2 gives one-word bursts. DRQ stays set until the last word of the burst has been read.
- R5: Every burst raises `irq` together with status 0x48. Transfer word k (blocks of 1024 words) comes from block address + k/1024, word k mod 1024, and the words are delivered in order.
- R6: After the last word of a burst that is not the final one, DRQ clears at once. Status then reads 0xC0 until the next burst begins.
- R7: A burst starts only while `src_ready` is high. While it waits, status reads 0xC0 and no interrupt is raised.
- R8: After the final word the sequencer raises a completion interrupt, and status settles at 0x40.
- R9: A host read of the status register clears a pending interrupt.
- R10: An opcode other than 0x28 ends the command with status 0x41, error register 0x04 and a completion interrupt. The next 0xA0 command clears both error indications.
- R11: A read with a block count of zero completes right away, with an interrupt, status 0x40 and no data phase.
- R12: These have no effect: command codes other than 0xA0, limit or command writes while a command is active, and data-port reads outside a burst (which return 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 3 | Task-file register address |
| hst_wdata | input | 16 | Host write data (byte registers use bits 7:0) |
| hst_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Interrupt request to the host |
| src_ready | input | 1 | Block source has data available for a burst |
| src_rd | output | 1 | Block source word read strobe |
| src_lba | output | 32 | Block address of the requested word |
| src_word | output | 10 | Word index within the block |
| src_rdata | input | 16 | Source word, valid the cycle after `src_rd` |

## Verification
A fault in the burst word counter shows up on the very next data read: DRQ is either still set after the word the host expected to be the last, or already clear before it. Either way the status read that follows disagrees at once. A fault in the transfer pointer or in the packet decoding corrupts the first word of the affected burst, because every word carries its block address and word index. A lost or spurious interrupt shows as a stuck wait or as an interrupt while the status is busy. The bench mixes random limits, block counts and source stalls with directed limits of 1, an odd value and the maximum.

// File: rtl/pkt_pio_burst_seq.sv
module pkt_pio_burst_seq #(
  parameter int BLK_LOG2 = 10,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_wr,
  input  logic                hst_rd,
  input  logic [2:0]          hst_addr,
  input  logic [15:0]         hst_wdata,
  output logic [15:0]         hst_rdata,
  output logic                irq,
  input  logic                src_ready,
  output logic                src_rd,
  output logic [31:0]         src_lba,
  output logic [BLK_LOG2-1:0] src_word,
  input  logic [15:0]         src_rdata
);
  localparam int REM_W = CNT_W + BLK_LOG2;
  localparam int BUR_W = 15;
  localparam logic [7:0] OP_READ = 8'h28;
  localparam logic [7:0] CMD_PKT = 8'hA0;

  typedef enum logic [2:0] {S_IDLE, S_PKT, S_DEC, S_PREP, S_LOAD, S_DATA} st_t;

  st_t              st;
  logic [15:0]      lim_q;
  logic             err_q;
  logic [2:0]       pidx;
  logic [7:0]       op_q;
  logic [31:0]      lba_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REM_W-1:0] rem_q, wptr_q, fptr;
  logic [BUR_W-1:0] bcnt_q, half_eff, burst_n;
  logic [15:0]      hold_q;
  logic             rd_q, irq_q;
  logic             drq, bsy, data_rd, stat_rd, cmd_wr, idle_wr, set_irq, last_word;
  logic [7:0]       status;

  assign drq       = (st == S_PKT) || (st == S_DATA);
  assign bsy       = (st == S_DEC) || (st == S_PREP) || (st == S_LOAD);
  assign status    = {bsy, 1'b1, 2'b00, drq, 2'b00, err_q};
  assign data_rd   = hst_rd && hst_addr == 3'd0 && st == S_DATA;
  assign stat_rd   = hst_rd && hst_addr == 3'd7;
  assign idle_wr   = hst_wr && st == S_IDLE;
  assign cmd_wr    = idle_wr && hst_addr == 3'd7 && hst_wdata[7:0] == CMD_PKT;
  assign last_word = data_rd && bcnt_q == BUR_W'(1);
  assign half_eff  = (lim_q[15:1] == '0) ? BUR_W'(1) : lim_q[15:1];
  assign burst_n   = (rem_q < REM_W'(half_eff)) ? rem_q[BUR_W-1:0] : half_eff;
  assign set_irq   = (st == S_LOAD)
                  || (st == S_DEC && (op_q != OP_READ || cnt_q == '0))
                  || (last_word && rem_q == REM_W'(1));

  assign src_rd   = (st == S_PREP && src_ready) || (data_rd && !last_word);
  assign fptr     = wptr_q + REM_W'(st == S_DATA);
  assign src_lba  = lba_q + 32'(fptr >> BLK_LOG2);
  assign src_word = fptr[BLK_LOG2-1:0];
  assign irq      = irq_q;

  always_comb begin
    case (hst_addr)
      3'd0:    hst_rdata = data_rd ? hold_q : 16'h0000;
      3'd1:    hst_rdata = {13'd0, err_q, 2'b00};
      3'd4:    hst_rdata = {8'h00, lim_q[7:0]};
      3'd5:    hst_rdata = {8'h00, lim_q[15:8]};
      3'd7:    hst_rdata = {8'h00, status};
      default: hst_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lim_q  <= '0;
      err_q  <= 1'b0;
      pidx   <= '0;
      op_q   <= '0;
      lba_q  <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      wptr_q <= '0;
      bcnt_q <= '0;
      hold_q <= '0;
      rd_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rd_q <= src_rd;
      if (rd_q) hold_q <= src_rdata;

      if (set_irq)                irq_q <= 1'b1;
      else if (stat_rd || cmd_wr) irq_q <= 1'b0;

      if (idle_wr && hst_addr == 3'd4) lim_q[7:0]  <= hst_wdata[7:0];
      if (idle_wr && hst_addr == 3'd5) lim_q[15:8] <= hst_wdata[7:0];

      case (st)
        S_IDLE: if (cmd_wr) begin
          st    <= S_PKT;
          pidx  <= '0;
          err_q <= 1'b0;
        end
        S_PKT: if (hst_wr && hst_addr == 3'd0) begin
          case (pidx)
            3'd0: op_q <= hst_wdata[7:0];
            3'd1: lba_q[31:16] <= {hst_wdata[7:0], hst_wdata[15:8]};
            3'd2: lba_q[15:0]  <= {hst_wdata[7:0], hst_wdata[15:8]};
            3'd3: cnt_q[15:8]  <= hst_wdata[15:8];
            3'd4: cnt_q[7:0]   <= hst_wdata[7:0];
            default: ;
          endcase
          pidx <= pidx + 3'd1;
          if (pidx == 3'd5) st <= S_DEC;
        end
        S_DEC: begin
          wptr_q <= '0;
          rem_q  <= REM_W'(cnt_q) << BLK_LOG2;
          if (op_q != OP_READ) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (cnt_q == '0) begin
            st <= S_IDLE;
          end else begin
            st <= S_PREP;
          end
        end
        S_PREP: if (src_ready) st <= S_LOAD;
        S_LOAD: begin
          bcnt_q <= burst_n;
          st     <= S_DATA;
        end
        S_DATA: if (data_rd) begin
          wptr_q <= wptr_q + REM_W'(1);
          rem_q  <= rem_q - REM_W'(1);
          bcnt_q <= bcnt_q - BUR_W'(1);
          if (last_word) st <= (rem_q == REM_W'(1)) ? S_IDLE : S_PREP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_burst_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (bcnt_q != '0 && REM_W'(bcnt_q) <= rem_q));

  p_burst_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |=> (irq_q && drq));

  p_drq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !drq);

  p_wait_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PREP && !src_ready) |=> (st == S_PREP));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && st == S_DATA && irq_q) |=> !irq_q);

  p_abort_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (irq_q && st == S_IDLE));
endmodule

// File: tb/tb_pkt_pio_burst_seq.sv
module tb_pkt_pio_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n, hst_wr, hst_rd, irq, src_ready, src_rd;
  logic [2:0]  hst_addr;
  logic [15:0] hst_wdata, hst_rdata, src_rdata;
  logic [31:0] src_lba;
  logic [9:0]  src_word;
  bit          rnd_rdy;
  int          errs = 0, checks = 0;

  always #4 clk = ~clk;

  pkt_pio_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq), .src_ready(src_ready),
    .src_rd(src_rd), .src_lba(src_lba), .src_word(src_word), .src_rdata(src_rdata));

  always_ff @(posedge clk) if (src_rd) src_rdata <= {src_lba[5:0], src_word};

  always @(negedge clk) if (rnd_rdy) src_ready = ($urandom % 4) != 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(posedge clk); #1 hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); hst_addr = a; hst_rd = 1'b1;
    #1 d = hst_rdata;
    @(posedge clk); #1 hst_rd = 1'b0;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  task automatic send_cmd(input logic [15:0] lim, input logic [7:0] feat);
    hwrite(3'd4, {8'h00, lim[7:0]});
    hwrite(3'd5, {8'h00, lim[15:8]});
    hwrite(3'd1, {8'h00, feat});
    hwrite(3'd7, 16'h00A0);
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] n);
    hwrite(3'd0, {8'h00, op});
    hwrite(3'd0, {lba[23:16], lba[31:24]});
    hwrite(3'd0, {lba[7:0], lba[15:8]});
    hwrite(3'd0, {n[15:8], 8'h00});
    hwrite(3'd0, {8'h00, n[7:0]});
    hwrite(3'd0, 16'h0000);
  endtask

  function automatic logic [15:0] exp_word(input logic [31:0] lba, input int k);
    logic [31:0] b = lba + 32'(k / 1024);
    return {b[5:0], 10'(k % 1024)};
  endfunction

  task automatic run_xfer(input logic [15:0] lim, input logic [31:0] lba, input int nblk,
                          input logic [7:0] feat, input bit hold_src, input bit poke);
    logic [15:0] s, d;
    int rem, k, half, n;
    bit ok;
    send_cmd(lim, feat);
    hread(3'd4, d); chk(d[7:0] == lim[7:0], "R2 limit low", d, lim[7:0]);
    hread(3'd5, d); chk(d[7:0] == lim[15:8], "R2 limit high", d, lim[15:8]);
    hread(3'd7, s); chk(s == 16'h48, "R2 packet DRQ", s, 16'h48);
    if (hold_src) begin rnd_rdy = 1'b0; src_ready = 1'b0; end
    send_pkt(8'h28, lba, 16'(nblk));
    if (hold_src) begin
      repeat (30) @(negedge clk);
      chk(irq == 1'b0, "R7 no irq while source not ready", irq, 0);
      hread(3'd7, s); chk(s == 16'hC0, "R7 R3 busy wait after packet", s, 16'hC0);
      src_ready = 1'b1;
    end
    rem = nblk * 1024; k = 0;
    half = int'(lim) / 2; if (half == 0) half = 1;
    while (rem > 0) begin
      wait_irq(ok);
      chk(ok, "R5 burst irq", ok, 1);
      if (!ok) return;
      hread(3'd7, s); chk(s == 16'h48, "R5 burst status", s, 16'h48);
      chk(irq == 1'b0, "R9 status read clears irq", irq, 0);
      if (poke) begin
        hwrite(3'd4, 16'h0011);
        hwrite(3'd7, 16'h00A0);
        hread(3'd4, d); chk(d[7:0] == lim[7:0], "R12 limit write while busy", d, lim[7:0]);
        hread(3'd7, s); chk(s == 16'h48, "R12 command while busy", s, 16'h48);
        poke = 1'b0;
      end
      n = (rem < half) ? rem : half;
      for (int i = 0; i < n; i++) begin
        if (i == n - 1 && n > 1) begin
          hread(3'd7, s); chk(s == 16'h48, "R4 DRQ held to last word", s, 16'h48);
        end
        hread(3'd0, d);
        chk(d == exp_word(lba, k), "R3 R5 data word", d, exp_word(lba, k));
        k++;
        @(posedge clk);
      end
      rem -= n;
      if (rem > 0) begin
        hread(3'd7, s); chk(s == 16'hC0, "R4 R6 DRQ drop after burst", s, 16'hC0);
      end
    end
    wait_irq(ok); chk(ok, "R8 completion irq", ok, 1);
    hread(3'd7, s); chk(s == 16'h40, "R8 final status", s, 16'h40);
    chk(irq == 1'b0, "R9 completion irq cleared", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] s, d;
    bit ok;
    void'($urandom(32'd4242));
    rst_n = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = '0; hst_wdata = '0;
    src_ready = 1'b1; rnd_rdy = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    hread(3'd7, s); chk(s == 16'h40, "R1 reset status", s, 16'h40);
    hread(3'd1, d); chk(d == 16'h0, "R1 reset error", d, 0);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    hwrite(3'd7, 16'h00EC);
    hread(3'd7, s); chk(s == 16'h40, "R12 foreign command ignored", s, 16'h40);
    hread(3'd0, d); chk(d == 16'h0, "R12 idle data read", d, 0);
    chk(irq == 1'b0, "R12 no irq from foreign command", irq, 0);

    run_xfer(16'd5120, 32'h0000_0010, 1, 8'h01, 1'b1, 1'b1);
    run_xfer(16'h0203, 32'h0001_0000, 1, 8'h00, 1'b0, 1'b0);
    run_xfer(16'h0001, 32'h0000_0003, 1, 8'h00, 1'b0, 1'b0);
    run_xfer(16'hFFFE, 32'hFFFF_FFFF, 2, 8'h00, 1'b0, 1'b0);

    send_cmd(16'h0100, 8'h00);
    send_pkt(8'h12, 32'h0, 16'd1);
    wait_irq(ok); chk(ok, "R10 abort irq", ok, 1);
    hread(3'd7, s); chk(s == 16'h41, "R10 abort status", s, 16'h41);
    hread(3'd1, d); chk(d == 16'h04, "R10 abort code", d, 16'h04);
    hwrite(3'd7, 16'h00A0);
    hread(3'd7, s); chk(s == 16'h48, "R10 error cleared by command", s, 16'h48);
    hread(3'd1, d); chk(d == 16'h00, "R10 error reg cleared", d, 0);
    send_pkt(8'h28, 32'h5, 16'd0);
    wait_irq(ok); chk(ok, "R11 zero-count irq", ok, 1);
    hread(3'd7, s); chk(s == 16'h40, "R11 zero-count status", s, 16'h40);
    hread(3'd0, d); chk(d == 16'h0, "R11 R12 no data phase", d, 0);

    rnd_rdy = 1'b1;
    for (int t = 0; t < 8; t++) begin
      logic [15:0] lim = 16'($urandom_range(0, 3000));
      logic [31:0] lba = $urandom;
      logic [7:0]  ft  = 8'($urandom);
      run_xfer(lim, lba, 1 + int'($urandom % 2), ft, 1'b0, 1'b0);
    end
    rnd_rdy = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule